// File: doc/BRIEF.md
# Strided Block Word Transfer Engine

This engine carries out one transfer between system memory and a peripheral FIFO. It is given a 64-bit memory start address, supplied as two 32-bit halves, and a fixed FIFO address. It is also given a block length in words, a gap in words between blocks, a block count and a direction. It walks memory as a two-level loop. The inner loop moves the words of one block at consecutive word addresses. The outer loop then skips the gap and starts the next block. The FIFO address never changes, because every word goes to or comes from the same FIFO.

Each word is moved alone. The source side is read first: a memory read with a later response, or a pop from the FIFO. The destination side is written next: a push into the FIFO, or a memory write. Every transfer waits for the receiving side's ready signal. A stop request halts the engine between words and keeps its position. A later start resumes from that position. A `done` pulse marks the end of the whole transfer.

Top module: `sbw_xfer_engine`

## Requirements
- R1: After synchronous reset, `busy`, `paused` and `done` are low, and `mem_req_valid`, `fifo_wvalid` and `fifo_rready` are low.
- R2: With `to_periph`=1, each word is read from memory (`mem_req_write`=0) and pushed into the FIFO unchanged, in address order.
- R3: With `to_periph`=0, each word is popped from the FIFO and written to memory (`mem_req_write`=1) unchanged, in arrival order.
- R4: Within a block, successive words use byte addresses that rise by 4. A block holds exactly `blk_words` words.
- R5: Exactly `blk_count` blocks are moved, so the total word count is `blk_words`×`blk_count`.
- R6: The first word of each block after the first lies `blk_gap` words beyond the last word of the previous block. A gap of 0 makes the blocks contiguous.
- R7: `fifo_addr` equals the `fifo_addr_in` value captured at start for every FIFO transfer of the job.
- R8: `mem_req_addr[63:32]` equals `mem_base_hi` and the low half starts at `mem_base_lo` for the whole job.
- R9: When `mem_req_valid` or `fifo_wvalid` is not accepted, the request and its address and data are held until accepted. No word is lost or repeated under stalls.
- R10: A start with `blk_words`=0 or `blk_count`=0 raises `done` on the cycle after the start with no bus activity.
- R11: `stop` halts the job after the word in flight completes: `paused`=1, `busy`=1, no bus activity. A later `start` resumes with the next word and no repeat.
- R12: `done` is a single-cycle pulse in the cycle right after the final word's destination handshake, and `busy` is low while `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a job when idle; resume when paused |
| stop | input | 1 | Halt at the next word boundary |
| to_periph | input | 1 | 1: memory to FIFO, 0: FIFO to memory |
| mem_base_lo | input | 32 | Memory start byte address, low half |
| mem_base_hi | input | 32 | Memory start byte address, high half |
| fifo_addr_in | input | 32 | FIFO address for the job |
| blk_words | input | 16 | Words per block |
| blk_gap | input | 16 | Words skipped between blocks |
| blk_count | input | 16 | Number of blocks |
| busy | output | 1 | Job loaded and not finished |
| paused | output | 1 | Job halted by stop |
| done | output | 1 | One-cycle completion pulse |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | 1: write, 0: read |
| mem_req_addr | output | 64 | Memory byte address |
| mem_req_wdata | output | 32 | Memory write data |
| mem_rvalid | input | 1 | Memory read data valid |
| mem_rdata | input | 32 | Memory read data |
| fifo_addr | output | 32 | FIFO address |
| fifo_wvalid | output | 1 | FIFO push valid |
| fifo_wready | input | 1 | FIFO push accepted |
| fifo_wdata | output | 32 | FIFO push data |
| fifo_rvalid | input | 1 | FIFO pop data valid |
| fifo_rready | output | 1 | FIFO pop request |
| fifo_rdata | input | 32 | FIFO pop data |

## Verification
The walk is tried with single-word blocks, multi-word blocks with and without a gap, and one long single block. Contiguous runs separate a missing gap from a wrong inner increment. Gapped runs expose a gap that is added on every word or applied in words instead of bytes. Both directions run with ready and valid patterns that stall on every second or third cycle, so a dropped or repeated word during backpressure shows up as a wrong word count or a data mismatch. Directed cases cover zero word and zero block counts, a stop in mid-block followed by resume, and the exact cycle of the completion pulse.

// File: rtl/sbw_pkg.sv
package sbw_pkg;

    parameter int ADDR_W = 64;
    parameter int HALF_W = ADDR_W / 2;
    parameter int DATA_W = 32;
    parameter int CNT_W  = 16;
    parameter int FIFO_AW = 32;
    parameter int WORD_BYTES = DATA_W / 8;
    parameter int WORD_SHIFT = $clog2(WORD_BYTES);

    typedef enum logic [1:0] {
        CT_IDLE,
        CT_RUN,
        CT_PAUSE
    } ctl_state_e;

    typedef enum logic [1:0] {
        MV_IDLE,
        MV_SRC,
        MV_WAIT,
        MV_DST
    } mv_state_e;

    typedef struct packed {
        logic [CNT_W-1:0] words;
        logic [CNT_W-1:0] gap;
        logic [CNT_W-1:0] blocks;
    } geom_t;

    // Address of the word after `a`; at a block end the gap is skipped too.
    function automatic logic [ADDR_W-1:0] step_addr(
        input logic [ADDR_W-1:0] a,
        input logic              block_end,
        input logic [CNT_W-1:0]  gap
    );
        logic [ADDR_W-1:0] skip;
        skip = block_end ? (ADDR_W'(gap) << WORD_SHIFT) : '0;
        return a + ADDR_W'(WORD_BYTES) + skip;
    endfunction

    function automatic logic geom_empty(input geom_t g);
        return (g.words == '0) || (g.blocks == '0);
    endfunction

endpackage

// File: rtl/sbw_addr_gen.sv
module sbw_addr_gen
    import sbw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              advance,
    input  logic [ADDR_W-1:0] base,
    input  geom_t             geom,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              final_word
);

    geom_t            g_q;
    logic [CNT_W-1:0] w_idx;
    logic [CNT_W-1:0] b_idx;
    logic             block_end;

    assign block_end  = (w_idx == g_q.words - CNT_W'(1));
    assign final_word = block_end && (b_idx == g_q.blocks - CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            g_q      <= '0;
            w_idx    <= '0;
            b_idx    <= '0;
            cur_addr <= '0;
        end else if (load) begin
            g_q      <= geom;
            w_idx    <= '0;
            b_idx    <= '0;
            cur_addr <= base;
        end else if (advance) begin
            if (block_end) begin
                w_idx <= '0;
                b_idx <= b_idx + CNT_W'(1);
            end else begin
                w_idx <= w_idx + CNT_W'(1);
            end
            cur_addr <= step_addr(cur_addr, block_end, g_q.gap);
        end
    end

    // Word completions never run past the programmed block length (R4).
    assert_word_in_block_R4: assert property (@(posedge clk) disable iff (rst)
        advance |-> (w_idx < g_q.words))
        else $error("word index beyond block length");

    // Word completions never run past the programmed block count (R5).
    assert_block_in_range_R5: assert property (@(posedge clk) disable iff (rst)
        advance |-> (b_idx < g_q.blocks))
        else $error("block index beyond block count");

endmodule

// File: rtl/sbw_word_mover.sv
module sbw_word_mover
    import sbw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              launch,
    input  logic              to_periph,
    output logic              idle,
    output logic              word_done,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_write,
    output logic [DATA_W-1:0] mem_req_wdata,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              fifo_wvalid,
    input  logic              fifo_wready,
    output logic [DATA_W-1:0] fifo_wdata,
    input  logic              fifo_rvalid,
    output logic              fifo_rready,
    input  logic [DATA_W-1:0] fifo_rdata
);

    mv_state_e         st;
    logic [DATA_W-1:0] hold;

    assign idle = (st == MV_IDLE);

    always_comb begin
        mem_req_valid = 1'b0;
        mem_req_write = 1'b0;
        fifo_wvalid   = 1'b0;
        fifo_rready   = 1'b0;
        word_done     = 1'b0;
        case (st)
            MV_SRC: begin
                if (to_periph) mem_req_valid = 1'b1;
                else           fifo_rready   = 1'b1;
            end
            MV_DST: begin
                if (to_periph) begin
                    fifo_wvalid = 1'b1;
                    word_done   = fifo_wready;
                end else begin
                    mem_req_valid = 1'b1;
                    mem_req_write = 1'b1;
                    word_done     = mem_req_ready;
                end
            end
            default: ;
        endcase
    end

    assign mem_req_wdata = hold;
    assign fifo_wdata    = hold;

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= MV_IDLE;
            hold <= '0;
        end else begin
            case (st)
                MV_IDLE: if (launch) st <= MV_SRC;
                MV_SRC: begin
                    if (to_periph) begin
                        if (mem_req_ready) st <= MV_WAIT;
                    end else if (fifo_rvalid) begin
                        hold <= fifo_rdata;
                        st   <= MV_DST;
                    end
                end
                MV_WAIT: begin
                    if (mem_rvalid) begin
                        hold <= mem_rdata;
                        st   <= MV_DST;
                    end
                end
                MV_DST: if (word_done) st <= MV_IDLE;
                default: st <= MV_IDLE;
            endcase
        end
    end

    // A stalled memory request keeps its kind and data (R9).
    assert_mem_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_write) && $stable(mem_req_wdata)))
        else $error("memory request dropped while stalled");

    // A stalled FIFO push keeps its data (R9).
    assert_fifo_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (fifo_wvalid && !fifo_wready) |=> (fifo_wvalid && $stable(fifo_wdata)))
        else $error("fifo push dropped while stalled");

    // Only one side is addressed at a time (R9).
    assert_one_side_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mem_req_valid, fifo_wvalid, fifo_rready}))
        else $error("more than one bus side active");

endmodule

// File: rtl/sbw_xfer_engine.sv
module sbw_xfer_engine
    import sbw_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic               stop,
    input  logic               to_periph,
    input  logic [HALF_W-1:0]  mem_base_lo,
    input  logic [HALF_W-1:0]  mem_base_hi,
    input  logic [FIFO_AW-1:0] fifo_addr_in,
    input  logic [CNT_W-1:0]   blk_words,
    input  logic [CNT_W-1:0]   blk_gap,
    input  logic [CNT_W-1:0]   blk_count,
    output logic               busy,
    output logic               paused,
    output logic               done,
    output logic               mem_req_valid,
    input  logic               mem_req_ready,
    output logic               mem_req_write,
    output logic [ADDR_W-1:0]  mem_req_addr,
    output logic [DATA_W-1:0]  mem_req_wdata,
    input  logic               mem_rvalid,
    input  logic [DATA_W-1:0]  mem_rdata,
    output logic [FIFO_AW-1:0] fifo_addr,
    output logic               fifo_wvalid,
    input  logic               fifo_wready,
    output logic [DATA_W-1:0]  fifo_wdata,
    input  logic               fifo_rvalid,
    output logic               fifo_rready,
    input  logic [DATA_W-1:0]  fifo_rdata
);

    ctl_state_e         st;
    logic               dir_q;
    logic               stop_q;
    logic               done_q;
    logic [FIFO_AW-1:0] fifo_addr_q;
    geom_t              geom_in;
    logic               load;
    logic               launch;
    logic               halt_req;
    logic               mv_idle;
    logic               mv_done;
    logic               final_word;

    assign geom_in  = '{words: blk_words, gap: blk_gap, blocks: blk_count};
    assign load     = (st == CT_IDLE) && start && !geom_empty(geom_in);
    assign halt_req = stop || stop_q;
    assign launch   = (st == CT_RUN) && mv_idle && !halt_req;

    always_ff @(posedge clk) begin
        if (rst) begin
            st          <= CT_IDLE;
            dir_q       <= 1'b0;
            stop_q      <= 1'b0;
            done_q      <= 1'b0;
            fifo_addr_q <= '0;
        end else begin
            done_q <= 1'b0;
            case (st)
                CT_IDLE: begin
                    stop_q <= 1'b0;
                    if (start) begin
                        if (geom_empty(geom_in)) begin
                            done_q <= 1'b1;
                        end else begin
                            dir_q       <= to_periph;
                            fifo_addr_q <= fifo_addr_in;
                            st          <= CT_RUN;
                        end
                    end
                end
                CT_RUN: begin
                    if (mv_done) begin
                        if (final_word) begin
                            st     <= CT_IDLE;
                            done_q <= 1'b1;
                            stop_q <= 1'b0;
                        end else if (halt_req) begin
                            st     <= CT_PAUSE;
                            stop_q <= 1'b0;
                        end
                    end else if (mv_idle && halt_req) begin
                        st     <= CT_PAUSE;
                        stop_q <= 1'b0;
                    end else if (stop) begin
                        stop_q <= 1'b1;
                    end
                end
                CT_PAUSE: if (start) st <= CT_RUN;
                default: st <= CT_IDLE;
            endcase
        end
    end

    assign busy      = (st != CT_IDLE);
    assign paused    = (st == CT_PAUSE);
    assign done      = done_q;
    assign fifo_addr = fifo_addr_q;

    sbw_addr_gen u_addr (
        .clk        (clk),
        .rst        (rst),
        .load       (load),
        .advance    (mv_done),
        .base       ({mem_base_hi, mem_base_lo}),
        .geom       (geom_in),
        .cur_addr   (mem_req_addr),
        .final_word (final_word)
    );

    sbw_word_mover u_mover (
        .clk           (clk),
        .rst           (rst),
        .launch        (launch),
        .to_periph     (dir_q),
        .idle          (mv_idle),
        .word_done     (mv_done),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_write (mem_req_write),
        .mem_req_wdata (mem_req_wdata),
        .mem_rvalid    (mem_rvalid),
        .mem_rdata     (mem_rdata),
        .fifo_wvalid   (fifo_wvalid),
        .fifo_wready   (fifo_wready),
        .fifo_wdata    (fifo_wdata),
        .fifo_rvalid   (fifo_rvalid),
        .fifo_rready   (fifo_rready),
        .fifo_rdata    (fifo_rdata)
    );

    // Outside an active run the buses are silent (R10, R11).
    assert_quiet_bus_R11: assert property (@(posedge clk) disable iff (rst)
        (st != CT_RUN) |-> (!mem_req_valid && !fifo_wvalid && !fifo_rready))
        else $error("bus activity while not running");

    // Completion is only reported from the idle state (R12).
    assert_done_idle_R12: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy)
        else $error("done raised while busy");

endmodule

// File: tb/sbw_xfer_engine_tb.sv
module sbw_xfer_engine_tb_top;

    typedef struct packed {
        logic       dir;
        logic [7:0] base;
        logic [7:0] words;
        logic [7:0] gap;
        logic [7:0] blocks;
        logic [1:0] stall;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 8'd4,   8'd4, 8'd0, 8'd3, 2'd0},
        '{1'b1, 8'd0,   8'd3, 8'd2, 8'd4, 2'd1},
        '{1'b0, 8'd16,  8'd2, 8'd5, 8'd3, 2'd2},
        '{1'b0, 8'd40,  8'd5, 8'd0, 8'd2, 2'd3},
        '{1'b1, 8'd100, 8'd1, 8'd7, 8'd5, 2'd3},
        '{1'b0, 8'd200, 8'd6, 8'd1, 8'd1, 2'd1}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0, stop = 1'b0, to_periph = 1'b0;
    logic [31:0] mem_base_lo = '0, mem_base_hi = '0, fifo_addr_in = '0;
    logic [15:0] blk_words = '0, blk_gap = '0, blk_count = '0;
    logic        busy, paused, done;
    logic        mem_req_valid, mem_req_write;
    logic        mem_req_ready = 1'b1;
    logic [63:0] mem_req_addr;
    logic [31:0] mem_req_wdata;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic [31:0] fifo_addr;
    logic        fifo_wvalid, fifo_rready;
    logic        fifo_wready = 1'b1;
    logic [31:0] fifo_wdata;
    logic        fifo_rvalid = 1'b1;
    logic [31:0] fifo_rdata;

    always #2 clk = ~clk;

    sbw_xfer_engine dut_i (
        .clk(clk), .rst(rst), .start(start), .stop(stop), .to_periph(to_periph),
        .mem_base_lo(mem_base_lo), .mem_base_hi(mem_base_hi), .fifo_addr_in(fifo_addr_in),
        .blk_words(blk_words), .blk_gap(blk_gap), .blk_count(blk_count),
        .busy(busy), .paused(paused), .done(done),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .fifo_addr(fifo_addr), .fifo_wvalid(fifo_wvalid), .fifo_wready(fifo_wready),
        .fifo_wdata(fifo_wdata), .fifo_rvalid(fifo_rvalid), .fifo_rready(fifo_rready),
        .fifo_rdata(fifo_rdata)
    );

    int checks = 0;
    int fails  = 0;
    logic [31:0] mem [0:255];
    logic [31:0] plog [0:255];
    int pn = 0, wn = 0, act = 0, bad_pa = 0, bad_hi = 0;
    int pcyc = 0, hs_cyc = 0, ncyc = 0;
    int src_idx = 0;
    logic [1:0]  stall = 2'd0;
    logic [31:0] exp_hi = '0, exp_pa = '0;

    assign fifo_rdata = 32'hA000_0000 + 32'(src_idx);

    // Bus models and monitors.
    always @(posedge clk) begin
        if (mem_req_valid || fifo_wvalid || fifo_rready) act = act + 1;
        if (mem_req_valid && mem_req_addr[63:32] != exp_hi) bad_hi = bad_hi + 1;
        if (fifo_wvalid && fifo_wready) begin
            plog[pn[7:0]] = fifo_wdata;
            pn = pn + 1;
            if (fifo_addr != exp_pa) bad_pa = bad_pa + 1;
            hs_cyc = pcyc;
        end
        if (fifo_rvalid && fifo_rready) src_idx <= src_idx + 1;
        if (mem_req_valid && mem_req_ready && mem_req_write) begin
            mem[mem_req_addr[9:2]] = mem_req_wdata;
            wn = wn + 1;
            hs_cyc = pcyc;
        end
        if (mem_req_valid && mem_req_ready && !mem_req_write) begin
            mem_rvalid <= 1'b1;
            mem_rdata  <= mem[mem_req_addr[9:2]];
        end else begin
            mem_rvalid <= 1'b0;
        end
        pcyc = pcyc + 1;
    end

    // Stall patterns and watchdog, driven away from the active edge.
    always @(negedge clk) begin
        ncyc = ncyc + 1;
        mem_req_ready <= stall[0] ? ncyc[1] : 1'b1;
        fifo_wready   <= stall[1] ? (ncyc % 3 != 0) : 1'b1;
        fifo_rvalid   <= stall[1] ? ncyc[0] : 1'b1;
        if (ncyc > 150000) begin
            fails = fails + 1;
            $display("FAIL watchdog act=%0d exp=0", ncyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act_v, input longint exp_v);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s act=%0h exp=%0h", tag, act_v, exp_v);
        end
    endtask

    task automatic init_mem();
        for (int i = 0; i < 256; i++) mem[i] = 32'hC0DE_0000 + 32'(i);
    endtask

    task automatic kick(input logic dir, input int base, input int w, input int g,
                        input int b, input logic [31:0] hi);
        @(negedge clk);
        to_periph    = dir;
        mem_base_lo  = 32'(base * 4);
        mem_base_hi  = hi;
        exp_hi       = hi;
        fifo_addr_in = 32'h4000_0000 + hi;
        exp_pa       = 32'h4000_0000 + hi;
        blk_words    = 16'(w);
        blk_gap      = 16'(g);
        blk_count    = 16'(b);
        start        = 1'b1;
        @(negedge clk);
        start        = 1'b0;
    endtask

    task automatic wait_done(output bit ok);
        ok = 1'b0;
        for (int t = 0; t < 4000; t++) begin
            if (done) begin ok = 1'b1; break; end
            @(negedge clk);
        end
    endtask

    initial begin
        bit ok;
        int src0, nexp, bad, n;
        init_mem();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(!busy && !paused && !done, "R1 status", {busy, paused, done}, 0);
        chk(!mem_req_valid && !fifo_wvalid && !fifo_rready, "R1 bus",
            {mem_req_valid, fifo_wvalid, fifo_rready}, 0);

        for (int v = 0; v < NVEC; v++) begin
            init_mem();
            stall = VECS[v].stall;
            pn = 0; wn = 0; bad_pa = 0; bad_hi = 0;
            src0 = src_idx;
            kick(VECS[v].dir, int'(VECS[v].base), int'(VECS[v].words),
                 int'(VECS[v].gap), int'(VECS[v].blocks), 32'h12 + 32'(v));
            wait_done(ok);
            chk(ok, "R12 done seen", ok, 1);
            // R12: done one cycle after the last destination handshake
            chk(pcyc == hs_cyc + 1, "R12 done timing", pcyc, hs_cyc + 1);
            nexp = int'(VECS[v].words) * int'(VECS[v].blocks);
            bad = 0;
            n = 0;
            for (int b = 0; b < int'(VECS[v].blocks); b++) begin
                for (int w = 0; w < int'(VECS[v].words); w++) begin
                    int a;
                    a = int'(VECS[v].base) + b * (int'(VECS[v].words) + int'(VECS[v].gap)) + w;
                    if (VECS[v].dir) begin
                        if (plog[n] != 32'hC0DE_0000 + 32'(a)) bad = bad + 1;
                    end else begin
                        if (mem[a] != 32'hA000_0000 + 32'(src0 + n)) bad = bad + 1;
                    end
                    n = n + 1;
                end
            end
            if (VECS[v].dir) begin
                chk(pn == nexp, "R5 R9 word count to fifo", pn, nexp);
                chk(bad == 0, "R2 R4 R6 fifo data order", bad, 0);
                chk(bad_pa == 0, "R7 fifo address", bad_pa, 0);
            end else begin
                chk(wn == nexp, "R5 R9 word count to memory", wn, nexp);
                chk(bad == 0, "R3 R4 R6 memory placement", bad, 0);
            end
            chk(bad_hi == 0, "R8 high address half", bad_hi, 0);
            @(negedge clk);
            chk(!done && !busy, "R12 single pulse", {done, busy}, 0);
        end

        // R10: zero word count and zero block count
        stall = 2'd0;
        for (int z = 0; z < 2; z++) begin
            act = 0;
            kick(1'b1, 0, (z == 0) ? 0 : 4, 0, (z == 0) ? 3 : 0, 32'h0);
            chk(done == 1'b1, "R10 immediate done", done, 1);
            repeat (3) @(negedge clk);
            chk(act == 0 && !busy, "R10 no bus activity", act, 0);
        end

        // R11: stop mid-block, hold, then resume
        init_mem();
        pn = 0;
        kick(1'b1, 0, 8, 0, 1, 32'h0);
        for (int t = 0; t < 200 && pn < 3; t++) @(negedge clk);
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
        for (int t = 0; t < 200 && !paused; t++) @(negedge clk);
        chk(paused && busy, "R11 paused", {paused, busy}, 2'b11);
        n = pn;
        act = 0;
        repeat (10) @(negedge clk);
        chk(pn == n && act == 0, "R11 no activity while paused", act, 0);
        chk(pn < 8, "R11 halted before end", pn, 7);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done(ok);
        chk(ok && pn == 8, "R11 resume count", pn, 8);
        bad = 0;
        for (int i = 0; i < 8; i++) if (plog[i] != 32'hC0DE_0000 + 32'(i)) bad = bad + 1;
        chk(bad == 0, "R11 resume order", bad, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule